// File: doc/BRIEF.md
# Indirect Clock-Synthesizer Register Window

This block gives a host one 32-bit control word through which it reaches a hidden bank of 64 eight-bit clock-synthesizer registers. Byte 1 of the word selects a bank entry and carries a write-enable flag. Byte 2 is the data byte. A host that writes byte 2 on its own stores that byte into the selected bank entry. A host that reads byte 2 on its own gets the contents of that entry back. The flag decides which of the two can happen.

The host uses a simple strobe interface with per-byte enables. The stored control word is always updated according to the byte enables. Only a write that touches byte 2 alone reaches the bank. The low two bits of byte 0 select one of four feedback-divider entries. The selected entry's value is driven out as a registered output, so downstream clock logic can follow it. A separate registered flag is raised when the low two bits of the PLL control entry equal 3, meaning the programmable video PLL drives the pixel clock.

Top module: `pll_win`

## Requirements
- R1: After reset the control word, every bank entry, `rdata_o`, `clk_sel_o`, `fbdiv_o` and `pix_pll_o` are all zero.
- R2: A write (`req_i`=1, `we_i`=1) updates each byte of the control word whose `be_i` bit is set and leaves the other bytes unchanged. With no write strobe, the word holds.
- R3: A write with `be_i`=4'b0100 while control bit 9 is 1 stores `wdata_i[23:16]` into the bank entry addressed by control bits [15:10].
- R4: A write with `be_i`=4'b0100 while control bit 9 is 0 leaves the bank unchanged.
- R5: A write with any `be_i` other than 4'b0100 never changes a bank entry.
- R6: A read (`req_i`=1, `we_i`=0) with `be_i`=4'b0100 while control bit 9 is 0 returns the addressed bank entry in `rdata_o[23:16]` and the stored control bytes in the other lanes.
- R7: Any other read returns the stored 32-bit control word unchanged.
- R8: `clk_sel_o` equals control bits [1:0] as they stood one cycle earlier.
- R9: `fbdiv_o` is the bank entry at index `FB_BASE` + `clk_sel`, registered one cycle after the bank and the control word.
- R10: `pix_pll_o` is 1 exactly when the low two bits of bank entry `PCTL_IDX` equal 3, registered one cycle later.
- R11: `rdata_o` is loaded on the clock edge that samples a read strobe and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte enables of the control word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| clk_sel_o | output | 2 | Registered clock-select code |
| fbdiv_o | output | 8 | Registered selected feedback-divider value |
| pix_pll_o | output | 1 | Registered: programmable PLL drives pixel clock |

## Verification
The hardest case to reach is a bank entry changing through a path the host does not intend. This can happen with a single-byte write to byte 2 while the flag is clear, or with a wider write that includes byte 2 while the flag is set. Either one is visible only through a later single-byte read taken with the flag cleared. The stimulus therefore gives the byte-2-only enable pattern about two times in five and flips the flag and address bytes often, so that reads taken with the flag clear keep exposing the bank. Directed steps first set up the feedback-divider and PLL-control entries and check the pixel-clock decode on both sides of the value 3.

// File: rtl/pll_win_pkg.sv
package pll_win_pkg;
  localparam int unsigned CW_W   = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NBYTE  = CW_W / BYTE_W;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned NUM_ENT = 1 << ADDR_W;
  localparam int unsigned SEL_W  = 2;
  // control-word field positions decoded by the bank path
  localparam int unsigned FLAG_BIT = 9;
  localparam int unsigned ADDR_LO  = 10;
  localparam int unsigned DATA_LO  = 16;
  localparam logic [NBYTE-1:0] BE_DATA = 4'b0100;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CW_W-1:0]   word_t;
endpackage

// File: rtl/pll_win_ctrl.sv
module pll_win_ctrl
  import pll_win_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [NBYTE-1:0] be_i,
  input  word_t            wdata_i,
  input  byte_t            bank_rd_i,
  output logic             pll_wr_o,
  output addr_t            pll_addr_o,
  output logic [SEL_W-1:0] sel_o,
  output word_t            rdata_o
);
  word_t ctrl_q;
  word_t ctrl_d;
  word_t rd_mux;
  logic  wr_req, rd_req, single_data;

  assign wr_req      = req_i && we_i;
  assign rd_req      = req_i && !we_i;
  assign single_data = (be_i == BE_DATA);

  always_comb begin
    ctrl_d = ctrl_q;
    for (int b = 0; b < NBYTE; b++)
      if (be_i[b]) ctrl_d[b*BYTE_W +: BYTE_W] = wdata_i[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    rd_mux = ctrl_q;
    if (single_data && !ctrl_q[FLAG_BIT])
      rd_mux[DATA_LO +: BYTE_W] = bank_rd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      rdata_o <= '0;
    end else begin
      if (wr_req) ctrl_q  <= ctrl_d;
      if (rd_req) rdata_o <= rd_mux;
    end
  end

  assign pll_wr_o   = wr_req && single_data && ctrl_q[FLAG_BIT];
  assign pll_addr_o = ctrl_q[ADDR_LO +: ADDR_W];
  assign sel_o      = ctrl_q[SEL_W-1:0];

  // R2
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req |=> $stable(ctrl_q));
  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(rdata_o));
endmodule

// File: rtl/pll_win_bank.sv
module pll_win_bank
  import pll_win_pkg::*;
#(
  parameter int unsigned PCTL_IDX = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  addr_t            wr_addr_i,
  input  byte_t            wr_data_i,
  input  addr_t            rd_addr_i,
  input  addr_t            fb_addr_i,
  output byte_t            rd_data_o,
  output byte_t            fb_data_o,
  output logic [1:0]       pctl_mode_o
);
  byte_t mem [NUM_ENT];
  logic [NUM_ENT*BYTE_W-1:0] mem_flat;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem[i] <= '0;
      else if (wr_en_i && wr_addr_i == addr_t'(i))    mem[i] <= wr_data_i;
    end
    assign mem_flat[i*BYTE_W +: BYTE_W] = mem[i];
  end

  assign rd_data_o   = mem[rd_addr_i];
  assign fb_data_o   = mem[fb_addr_i];
  assign pctl_mode_o = mem[PCTL_IDX][1:0];

  // R4
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mem_flat));
endmodule

// File: rtl/pll_win_out.sv
module pll_win_out
  import pll_win_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  byte_t            fb_data_i,
  input  logic [1:0]       pctl_mode_i,
  output logic [SEL_W-1:0] clk_sel_o,
  output byte_t            fbdiv_o,
  output logic             pix_pll_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sel_o <= '0;
      fbdiv_o   <= '0;
      pix_pll_o <= 1'b0;
    end else begin
      clk_sel_o <= sel_i;
      fbdiv_o   <= fb_data_i;
      pix_pll_o <= (pctl_mode_i == 2'd3);
    end
  end
endmodule

// File: rtl/pll_win.sv
module pll_win
  import pll_win_pkg::*;
#(
  parameter int unsigned FB_BASE  = 7,
  parameter int unsigned PCTL_IDX = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic [1:0]  clk_sel_o,
  output logic [7:0]  fbdiv_o,
  output logic        pix_pll_o
);
  logic             pll_wr;
  addr_t            pll_addr;
  logic [SEL_W-1:0] sel;
  byte_t            bank_rd, fb_data;
  logic [1:0]       pctl_mode;
  addr_t            fb_addr;

  assign fb_addr = addr_t'(FB_BASE) + addr_t'(sel);

  pll_win_ctrl u_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .be_i, .wdata_i,
    .bank_rd_i (bank_rd),
    .pll_wr_o  (pll_wr),
    .pll_addr_o(pll_addr),
    .sel_o     (sel),
    .rdata_o
  );

  pll_win_bank #(.PCTL_IDX(PCTL_IDX)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i    (pll_wr),
    .wr_addr_i  (pll_addr),
    .wr_data_i  (wdata_i[DATA_LO +: BYTE_W]),
    .rd_addr_i  (pll_addr),
    .fb_addr_i  (fb_addr),
    .rd_data_o  (bank_rd),
    .fb_data_o  (fb_data),
    .pctl_mode_o(pctl_mode)
  );

  pll_win_out u_out (
    .clk_i, .rst_ni,
    .sel_i      (sel),
    .fb_data_i  (fb_data),
    .pctl_mode_i(pctl_mode),
    .clk_sel_o, .fbdiv_o, .pix_pll_o
  );

  // R5
  multi_no_pll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && be_i != BE_DATA) |-> !pll_wr);
  // R8
  clk_sel_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> clk_sel_o == $past(sel));
  // R10
  pix_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pix_pll_o == ($past(pctl_mode) == 2'd3));
endmodule

// File: tb/pll_win_bench.sv
`timescale 1ns/1ps
module pll_win_bench;
  localparam int FB_BASE  = 7;
  localparam int PCTL_IDX = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  clk_sel;
  logic [7:0]  fbdiv;
  logic        pix;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] ctrl_m;
  logic [7:0]  bank_m [64];

  always #2 clk = ~clk;

  pll_win #(.FB_BASE(FB_BASE), .PCTL_IDX(PCTL_IDX)) u_pll_win (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .be_i(be),
    .wdata_i(wdata), .rdata_o(rdata), .clk_sel_o(clk_sel),
    .fbdiv_o(fbdiv), .pix_pll_o(pix)
  );

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [3:0] b);
    logic [31:0] r = ctrl_m;
    if (b == 4'b0100 && !ctrl_m[9]) r[23:16] = bank_m[ctrl_m[15:10]];
    return r;
  endfunction

  task automatic chk_outs();
    logic [1:0] s = ctrl_m[1:0];
    check("R8",  {30'd0, clk_sel}, {30'd0, s});
    check("R9",  {24'd0, fbdiv}, {24'd0, bank_m[6'(FB_BASE + int'(s))]});
    check("R10", {31'd0, pix}, {31'd0, bank_m[PCTL_IDX][1:0] == 2'd3});
  endtask

  task automatic do_wr(logic [3:0] b, logic [31:0] d);
    if (b == 4'b0100 && ctrl_m[9]) bank_m[ctrl_m[15:10]] = d[23:16];
    for (int i = 0; i < 4; i++) if (b[i]) ctrl_m[i*8 +: 8] = d[i*8 +: 8];
    req = 1; we = 1; be = b; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    @(negedge clk);
    chk_outs();
  endtask

  task automatic do_rd(logic [3:0] b);
    logic [31:0] e = exp_read(b);
    req = 1; we = 0; be = b; wdata = $urandom;
    @(negedge clk);
    req = 0;
    check((b == 4'b0100 && !ctrl_m[9]) ? "R6" : "R7", rdata, e);
    @(negedge clk);
    check("R11", rdata, e);
    chk_outs();
  endtask

  // write bank entry a with value v via the flag path
  task automatic put_bank(logic [5:0] a, logic [7:0] v);
    do_wr(4'b0010, {16'd0, a, 2'b10, 8'd0});
    do_wr(4'b0100, {8'd0, v, 16'd0});
  endtask

  initial begin
    ctrl_m = '0;
    for (int i = 0; i < 64; i++) bank_m[i] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", rdata, 32'd0);
    check("R1", {30'd0, clk_sel}, 32'd0);
    check("R1", {24'd0, fbdiv}, 32'd0);
    check("R1", {31'd0, pix}, 32'd0);
    do_rd(4'b1111);
    // R3 feedback-divider entries
    put_bank(6'd7, 8'h5A);
    put_bank(6'd8, 8'hC3);
    put_bank(6'd10, 8'h11);
    do_wr(4'b0001, 32'h0000_0001); // R8 select 1
    do_wr(4'b0001, 32'h0000_0003);
    // R10 decode around 3
    put_bank(6'(PCTL_IDX), 8'h03);
    put_bank(6'(PCTL_IDX), 8'h07);
    put_bank(6'(PCTL_IDX), 8'h02);
    // R4 flag clear: data byte stored, bank untouched
    do_wr(4'b0010, {16'd0, 6'd7, 2'b00, 8'd0});
    do_wr(4'b0100, 32'h00EE_0000);
    do_rd(4'b0100); // R6 returns 0x5A
    // R5 wide write with flag set
    do_wr(4'b0010, {16'd0, 6'd7, 2'b10, 8'd0});
    do_wr(4'b1100, 32'h9977_0000);
    do_wr(4'b0110, 32'h0044_1E00);
    do_rd(4'b0100); // R7 flag set
    do_wr(4'b0010, {16'd0, 6'd7, 2'b00, 8'd0});
    do_rd(4'b0100);
    do_rd(4'b0110);
    // random
    for (int k = 0; k < 1500; k++) begin
      int unsigned p = $urandom_range(0, 9);
      logic [3:0] b = (p < 4) ? 4'b0100 : (p < 6) ? 4'b0010 : 4'($urandom);
      if ($urandom_range(0, 2) == 0) do_rd(b);
      else do_wr(b, $urandom);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule